// File: doc/BRIEF.md
# Near-Base Complement Multiplier

This block multiplies two unsigned K-bit operands that sit just under the base 2^K. Each operand is replaced by its distance from the base. The two distances are multiplied by a narrow K/2-bit multiplier. The product is then rebuilt from a high part, which is the multiplicand minus the multiplier's distance, shifted left by K, plus the distance product. The main path uses one narrow multiply, one add, three subtracts and one shift, so no full-width multiplier is needed.

An operation starts with a one-cycle strobe that carries both operands. The block then steps through four phases: capture, deviation, multiply and combine. The result appears with a one-cycle done pulse. If either distance does not fit the narrow multiplier, the block takes a slower shift-and-add route instead. A flag reported with the result marks that route. The base exponent K is a parameter. It must be even and at least 4.

Top module: `nb_mult`

## Requirements
- R1: Each deviation equals 2^K minus its operand. It is formed at K+1 bits, so an operand of 0 gives a deviation of 2^K.
- R2: The fast path is taken exactly when both deviations are below 2^(K/2). The `fallback` output is 0 for a fast-path result and 1 for a result from the shift-and-add route.
- R3: On the fast path, `product` equals ((multiplicand − multiplier deviation) << K) + (multiplicand deviation × multiplier deviation). This is the true product of the two operands.
- R4: On the fast path, `done` rises exactly 4 clock edges after the edge that samples `start`.
- R5: When a deviation is 2^(K/2) or larger, `product` is still the exact unsigned product, computed by shift-and-add.
- R6: On the shift-and-add route, `done` rises exactly K+3 clock edges after the edge that samples `start`.
- R7: `done` is high for exactly one cycle per operation.
- R8: A `start` that arrives while an operation is in progress is ignored. The operation in flight completes with its own operands, and no extra `done` follows.
- R9: After reset, `product` is 0 and `done` and `fallback` are 0.
- R10: `product` and `fallback` keep their values from one `done` pulse until the next.
- R11: With K=16, operands 65531 and 65532 give deviations 5 and 4, a deviation product of 20, a high part of 65527 and a product of 4294377492. This is the fast-path step sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation using the operands present on this edge |
| mcand | input | K | Multiplicand, unsigned |
| mplier | input | K | Multiplier, unsigned |
| product | output | 2K | Full-width product, held until the next result |
| done | output | 1 | One-cycle pulse when `product` is updated |
| fallback | output | 1 | 1 if the current result came from the shift-and-add route |

## Verification
The hardest situation to reach from the ports is the boundary of the routing decision. Near that boundary, a deviation of exactly 2^(K/2)−1 must stay on the narrow multiplier, and a deviation one larger must switch to the slow route. The stimulus drives those two operand values on either side of the boundary. It also drives a zero operand, whose deviation needs the extra top bit. The bench separates the two routes by counting clock edges to `done`. A second tricky case is a `start` pulse during an operation in flight. The bench raises `start` with different operands in the middle of a run. It then confirms that the original product comes out and that no second pulse follows.

// File: rtl/nb_pkg.sv
package nb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_DEV  = 3'd1,
      ST_MUL  = 3'd2,
      ST_COMB = 3'd3,
      ST_SLOW = 3'd4
   } nb_state_e;
endpackage

// File: rtl/nb_deviation.sv
// Distance of an operand below the base 2^K, with a flag that says
// whether it fits the narrow multiplier (below 2^H).
module nb_deviation #(
   parameter int K = 16,
   parameter int H = K / 2
) (
   input  logic [K-1:0] x,
   output logic [K:0]   dev,
   output logic         wide
);
   localparam logic [K:0] BASE = {1'b1, {K{1'b0}}};

   always_comb begin
      dev  = BASE - {1'b0, x};
      wide = |dev[K:H];
   end
endmodule

// File: rtl/nb_dev_mul.sv
// Narrow H x H multiplier for the deviations. ARRAY selects an explicit
// partial-product array instead of the inferred operator.
module nb_dev_mul #(
   parameter int H     = 8,
   parameter bit ARRAY = 1'b1
) (
   input  logic [H-1:0]   a,
   input  logic [H-1:0]   b,
   output logic [2*H-1:0] p
);
   localparam int PW = 2 * H;

   generate
      if (ARRAY) begin : g_array
         logic [PW-1:0] pp [H];
         for (genvar i = 0; i < H; i++) begin : g_row
            assign pp[i] = b[i] ? ({{H{1'b0}}, a} << i) : '0;
         end
         always_comb begin
            p = '0;
            for (int j = 0; j < H; j++) begin
               p = p + pp[j];
            end
         end
      end else begin : g_op
         assign p = {{H{1'b0}}, a} * {{H{1'b0}}, b};
      end
   endgenerate
endmodule

// File: rtl/nb_serial_mul.sv
// Shift-and-add fallback multiplier: one multiplier bit per cycle, K steps.
module nb_serial_mul #(
   parameter int K = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [K-1:0]   a,
   input  logic [K-1:0]   b,
   output logic           fin,
   output logic [2*K-1:0] result
);
   localparam int CW = $clog2(K);
   localparam logic [CW-1:0] LAST = CW'(K - 1);

   logic [2*K-1:0] acc_q;
   logic [2*K-1:0] mc_q;
   logic [K-1:0]   mp_q;
   logic [CW-1:0]  cnt_q;
   logic           busy_q;
   logic           fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mc_q   <= '0;
         mp_q   <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go && !busy_q) begin
            acc_q  <= '0;
            mc_q   <= {{K{1'b0}}, a};
            mp_q   <= b;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (mp_q[0]) begin
               acc_q <= acc_q + mc_q;
            end
            mc_q  <= mc_q << 1;
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               fin_q  <= 1'b1;
            end
         end
      end
   end

   assign fin    = fin_q;
   assign result = acc_q;

   // R6: the finish pulse comes only after exactly K steps of a busy run
   p_fin_after_k_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> ($past(busy_q) && $past(cnt_q) == LAST));

   // R6: a run cannot be restarted before it has finished
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> busy_q);
endmodule

// File: rtl/nb_mult.sv
module nb_mult #(
   parameter int K         = 16,
   parameter bit MUL_ARRAY = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [K-1:0]   mcand,
   input  logic [K-1:0]   mplier,
   output logic [2*K-1:0] product,
   output logic           done,
   output logic           fallback
);
   import nb_pkg::*;

   localparam int H  = K / 2;
   localparam int PW = 2 * K;

   initial begin
      if (K < 4 || (K % 2) != 0) begin
         $fatal(1, "nb_mult: K must be even and at least 4");
      end
   end

   nb_state_e      st;
   logic [K-1:0]   a_q, b_q;
   logic [H-1:0]   da_q, db_q;
   logic [K-1:0]   hi_q;
   logic [K-1:0]   dp_q;
   logic [PW-1:0]  prod_q;
   logic           done_q, fb_q;

   logic [K:0]     dev_a, dev_b;
   logic           wide_a, wide_b, wide_any;
   logic [K-1:0]   dp_w;
   logic           ser_fin;
   logic [PW-1:0]  ser_res;
   logic           ser_go;

   nb_deviation #(.K(K), .H(H)) u_dev_a (.x(a_q), .dev(dev_a), .wide(wide_a));
   nb_deviation #(.K(K), .H(H)) u_dev_b (.x(b_q), .dev(dev_b), .wide(wide_b));
   assign wide_any = wide_a | wide_b;

   nb_dev_mul #(.H(H), .ARRAY(MUL_ARRAY)) u_dmul (
      .a(da_q), .b(db_q), .p(dp_w)
   );

   assign ser_go = (st == ST_DEV) && wide_any;

   nb_serial_mul #(.K(K)) u_ser (
      .clk(clk), .rst_n(rst_n), .go(ser_go),
      .a(a_q), .b(b_q), .fin(ser_fin), .result(ser_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         a_q    <= '0;
         b_q    <= '0;
         da_q   <= '0;
         db_q   <= '0;
         hi_q   <= '0;
         dp_q   <= '0;
         prod_q <= '0;
         done_q <= 1'b0;
         fb_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  a_q <= mcand;
                  b_q <= mplier;
                  st  <= ST_DEV;
               end
            end
            ST_DEV: begin
               da_q <= dev_a[H-1:0];
               db_q <= dev_b[H-1:0];
               st   <= wide_any ? ST_SLOW : ST_MUL;
            end
            ST_MUL: begin
               dp_q <= dp_w;
               hi_q <= a_q - {{(K-H){1'b0}}, db_q};
               st   <= ST_COMB;
            end
            ST_COMB: begin
               prod_q <= {hi_q, {K{1'b0}}} + {{K{1'b0}}, dp_q};
               fb_q   <= 1'b0;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            ST_SLOW: begin
               if (ser_fin) begin
                  prod_q <= ser_res;
                  fb_q   <= 1'b1;
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign product  = prod_q;
   assign done     = done_q;
   assign fallback = fb_q;

   // R7: done never lasts two cycles
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R3: fast-path result equals the true product of the captured operands
   p_fast_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !fb_q) |-> prod_q == ({{K{1'b0}}, a_q} * {{K{1'b0}}, b_q}));

   // R5: fallback result equals the true product as well
   p_slow_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && fb_q) |-> prod_q == ({{K{1'b0}}, a_q} * {{K{1'b0}}, b_q}));

   // R2: routing out of the deviation phase follows the width flag
   p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV) |=> ((st == ST_SLOW) == $past(wide_any)));

   // R4: a narrow case reaches done three edges after the deviation phase
   p_fast_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV && !wide_any) |-> ##3 (done_q && !fb_q));

   // R10: result is held between done pulses
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> ($stable(prod_q) && $stable(fb_q)));

   // R8: operands stay frozen while an operation is in flight
   p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/sim_nb_mult.sv
module sim_nb_mult;
   localparam int K  = 16;
   localparam int H  = K / 2;
   localparam int PW = 2 * K;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [K-1:0]   mcand = '0;
   logic [K-1:0]   mplier = '0;
   logic [PW-1:0]  product;
   logic           done;
   logic           fallback;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   nb_mult #(.K(K)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mcand(mcand), .mplier(mplier),
      .product(product), .done(done), .fallback(fallback)
   );

   initial begin
      #1_500_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_mul(input logic [K-1:0] a, input logic [K-1:0] b);
      return {48'd0, a} * {48'd0, b};
   endfunction

   function automatic bit is_wide(input logic [K-1:0] x);
      return ((32'd1 << K) - {16'd0, x}) >= (32'd1 << H);
   endfunction

   // Runs one operation; checks product, route flag, latency, pulse width and hold.
   task automatic run_op(input logic [K-1:0] a, input logic [K-1:0] b, input string tag);
      bit exp_fb;
      int lat;
      int exp_lat;
      logic [63:0] exp_p;
      exp_fb  = is_wide(a) || is_wide(b);
      exp_lat = exp_fb ? (K + 3) : 4;
      exp_p   = ref_mul(a, b);
      @(negedge clk);
      start = 1'b1; mcand = a; mplier = b;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      chk(done == 1'b1, {tag, " R7 done seen"}, 64'(done), 64'd1);
      chk(product == exp_p[PW-1:0], exp_fb ? {tag, " R5 product"} : {tag, " R3 product"},
          64'(product), exp_p);
      chk(fallback == exp_fb, {tag, " R2 route flag"}, 64'(fallback), 64'(exp_fb));
      chk(lat == exp_lat, exp_fb ? {tag, " R6 latency"} : {tag, " R4 latency"},
          64'(lat), 64'(exp_lat));
      @(negedge clk);
      chk(done == 1'b0, {tag, " R7 single pulse"}, 64'(done), 64'd0);
      chk(product == exp_p[PW-1:0], {tag, " R10 product held"}, 64'(product), exp_p);
   endtask

   task automatic t_reset;
      chk(product == '0, "R9 reset product", 64'(product), 64'd0);
      chk(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
      chk(fallback == 1'b0, "R9 reset fallback", 64'(fallback), 64'd0);
   endtask

   task automatic t_worked_example;
      // R11: deviations 5 and 4, product 20, high part 65527
      run_op(16'd65531, 16'd65532, "R11 worked");
      chk(product == 32'd4294377492, "R11 final value", 64'(product), 64'd4294377492);
      chk(product[K-1:0] == 16'd20, "R11 low half = deviation product", 64'(product[K-1:0]), 64'd20);
      chk(product[PW-1:K] == 16'd65527, "R11 high half = high part", 64'(product[PW-1:K]), 64'd65527);
   endtask

   task automatic t_boundaries;
      run_op(16'hFFFF, 16'hFFFF, "R3 base-1 squared");
      run_op(16'd65281, 16'd65281, "R2 deviation 255 both");
      run_op(16'd65280, 16'hFFFF, "R2 deviation 256 multiplicand");
      run_op(16'hFFFF, 16'd65280, "R2 deviation 256 multiplier");
      run_op(16'd0, 16'd12345, "R1 zero operand");
      run_op(16'd54321, 16'd0, "R1 zero multiplier");
      run_op(16'd1, 16'd1, "R5 tiny operands");
   endtask

   task automatic t_busy_ignore;
      logic [63:0] exp_p;
      int extra;
      exp_p = ref_mul(16'd65500, 16'd65520);
      @(negedge clk);
      start = 1'b1; mcand = 16'd65500; mplier = 16'd65520;
      @(negedge clk);
      start = 1'b1; mcand = 16'd3; mplier = 16'd7;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk(product == exp_p[PW-1:0], "R8 in-flight operands kept", 64'(product), exp_p);
      extra = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R8 no extra done", 64'(extra), 64'd0);
      chk(product == exp_p[PW-1:0], "R10 held across idle", 64'(product), exp_p);
   endtask

   task automatic t_random_near;
      for (int i = 0; i < 30; i++) begin
         logic [K-1:0] a, b;
         a = 16'(32'd65536 - (32'd1 + ($urandom % 255)));
         b = 16'(32'd65536 - (32'd1 + ($urandom % 255)));
         run_op(a, b, "R3 random near-base");
      end
   endtask

   task automatic t_random_wide;
      for (int i = 0; i < 12; i++) begin
         logic [K-1:0] a, b;
         a = 16'($urandom);
         b = 16'(32'd65536 - (32'd1 + ($urandom % 600)));
         run_op(a, b, "R5 random mixed");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_worked_example();
      t_boundaries();
      t_busy_ignore();
      t_random_near();
      t_random_wide();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule